// File: doc/BRIEF.md
# Byte-Parallel Four-Phase Handshake Sender

This block takes a sample word from an upstream producer and delivers it to a host over an 8-bit parallel bus. An active-low frame strobe tells the host when the bus carries a valid byte. The host acknowledges each byte with a level signal that it first raises and later lowers. The word is split into four byte chunks and sent least significant chunk first. Each chunk goes through a complete four-phase exchange before the next chunk is placed on the bus.

The upstream side is a valid/ready stream. `in_ready` is high only while the sender is idle, and a word transfers on any clock edge where both `in_valid` and `in_ready` are high. While a word is in flight, `in_ready` stays low, so the producer has to hold its word or retry later. A word offered during that time is not taken and has no effect. The acknowledge input is asynchronous to `clk` and passes through a synchroniser inside the block. A sample narrower than the four-chunk word is padded with zeros at the top.

Top module: `byte_handshake_tx`

## Requirements
- R1: During reset and while idle, `frame_n` is 1, `bus_data` is 0 and `in_ready` is 1.
- R2: Whenever `frame_n` is 1, `bus_data` is 0.
- R3: A chunk appears on `bus_data` in the same cycle that `frame_n` goes to 0. It stays unchanged for as long as `frame_n` stays 0.
- R4: `frame_n` stays 0 until the acknowledge has been seen high through the 2-flop synchroniser. It rises on the third rising edge of `clk`, counting the first edge that samples `host_ack` high as the first.
- R5: Between chunks, `frame_n` stays 1 for at least MIN_GAP cycles (default 2). The next chunk is not shown until the synchronised acknowledge is low again.
- R6: The chunks are sent in this order: bits 7:0, then 15:8, then 23:16, then 31:24 of the zero-extended word.
- R7: When the fourth chunk's exchange has finished, the block returns to idle and `in_ready` goes back to 1.
- R8: `in_ready` is 1 only when idle. A word offered while `in_ready` is 0 is ignored, and the chunks of the word in flight are sent unchanged.
- R9: A sample of SAMPLE_W bits (default 24) is zero-extended to 32 bits, so the top chunk carries 8'h00 by default.
- R10: When a word is accepted at a clock edge, its first chunk is on the bus with `frame_n` at 0 directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word offered |
| in_ready | output | 1 | Sender idle, word will be accepted |
| in_data | input | SAMPLE_W | Sample word |
| host_ack | input | 1 | Host acknowledge, asynchronous |
| frame_n | output | 1 | Active-low byte-valid strobe |
| bus_data | output | 8 | Byte bus, zero when frame_n is high |

## Verification
`frame_n`, `bus_data` and `in_ready` are decoded directly from state. Acceptance therefore shows up just after the accepting edge. An acknowledge edge shows up after three edges: two synchroniser stages and then the state update. The bench carries a behavioural model that is advanced on every rising edge using the same inputs the design sees. All three outputs are compared against the model on every falling edge, so each result is checked in the exact cycle it is due. A host process answers with a different delay for each word, and the chunks it collects are reassembled and checked against the sent word. Idle-gap lengths and offers made while busy are checked separately at the ports.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SHOW = 2'd1,
    ST_HOLD = 2'd2
  } tx_state_t;
endpackage

// File: rtl/bht_ack_sync.sv
module bht_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bht_chunk_pick.sv
module bht_chunk_pick #(
  parameter int CHUNK_W    = 8,
  parameter int NUM_CHUNKS = 4,
  localparam int WORD_W    = CHUNK_W * NUM_CHUNKS,
  localparam int IDX_W     = $clog2(NUM_CHUNKS)
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [IDX_W-1:0]   idx,
  output logic [CHUNK_W-1:0] chunk
);
  logic [CHUNK_W-1:0] slices [NUM_CHUNKS];

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_slice
    assign slices[g] = word[g*CHUNK_W +: CHUNK_W];
  end

  assign chunk = slices[idx];
endmodule

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
#(
  parameter int NUM_CHUNKS = 4,
  parameter int MIN_GAP    = 2,
  localparam int IDX_W     = $clog2(NUM_CHUNKS),
  localparam int GAP_W     = $clog2(MIN_GAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             ack_s,
  output logic             in_ready,
  output logic             load,
  output logic             show,
  output logic [IDX_W-1:0] idx
);
  tx_state_t        state;
  logic [GAP_W-1:0] gap_cnt;
  logic             gap_done;
  logic             last_chunk;

  assign gap_done   = (gap_cnt == GAP_W'(MIN_GAP - 1));
  assign last_chunk = (idx == IDX_W'(NUM_CHUNKS - 1));
  assign in_ready   = (state == ST_IDLE);
  assign load       = in_ready && in_valid;
  assign show       = (state == ST_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state <= ST_SHOW;
            idx   <= '0;
          end
        end
        ST_SHOW: begin
          if (ack_s) begin
            state   <= ST_HOLD;
            gap_cnt <= '0;
          end
        end
        ST_HOLD: begin
          if (!gap_done) gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_done && !ack_s) begin
            if (last_chunk) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_SHOW;
              idx   <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a shown chunk is held until the synchronised acknowledge arrives
  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHOW && !ack_s) |=> (state == ST_SHOW));

  // R5: frame stays released for the minimum gap
  p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !gap_done) |=> (state == ST_HOLD));

  // R5: next chunk waits for acknowledge low
  p_wait_ack_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && ack_s) |=> (state == ST_HOLD));

  // R6: chunks advance one index at a time
  p_chunk_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && gap_done && !ack_s && !last_chunk)
      |=> (state == ST_SHOW && idx == $past(idx) + IDX_W'(1)));

  // R7: idle again after the last chunk
  p_back_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && gap_done && !ack_s && last_chunk) |=> in_ready);
endmodule

// File: rtl/byte_handshake_tx.sv
module byte_handshake_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int CHUNK_W     = 8,
  parameter int NUM_CHUNKS  = 4,
  parameter int MIN_GAP     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = CHUNK_W * NUM_CHUNKS,
  localparam int IDX_W      = $clog2(NUM_CHUNKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                host_ack,
  output logic                frame_n,
  output logic [CHUNK_W-1:0]  bus_data
);
  logic              ack_s;
  logic              load;
  logic              show;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_ext;
  logic [WORD_W-1:0] word_q;
  logic [CHUNK_W-1:0] chunk;

  if (SAMPLE_W < WORD_W) begin : g_pad
    assign word_ext = {{(WORD_W - SAMPLE_W){1'b0}}, in_data};
  end else begin : g_full
    assign word_ext = in_data[WORD_W-1:0];
  end

  bht_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(host_ack), .sync_out(ack_s)
  );

  bht_ctrl #(.NUM_CHUNKS(NUM_CHUNKS), .MIN_GAP(MIN_GAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ack_s(ack_s),
    .in_ready(in_ready), .load(load), .show(show), .idx(idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_ext;
  end

  bht_chunk_pick #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_pick (
    .word(word_q), .idx(idx), .chunk(chunk)
  );

  assign frame_n  = !show;
  assign bus_data = show ? chunk : '0;

  // R2: bus is quiet while frame is high
  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> (bus_data == '0));

  // R3: byte stable while frame stays low
  p_stable_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !$past(frame_n)) |-> (bus_data == $past(bus_data)));

  // R8: ready only while frame released
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> frame_n);

  // R10: accepted word shows its first chunk next cycle
  p_accept_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !frame_n);
endmodule

// File: tb/byte_handshake_tx_test.sv
module byte_handshake_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic host_ack = 1'b0;
  logic in_ready, frame_n;
  logic [7:0] bus_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int ack_delay = 0;
  int drop_delay = 0;
  logic [7:0] rx_q[$];

  // behavioural reference
  int m_phase = 0, m_byte = 0, m_hold = 0;
  logic [31:0] m_word = '0;
  logic s1 = 1'b0, s2 = 1'b0;

  byte_handshake_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .host_ack(host_ack), .frame_n(frame_n), .bus_data(bus_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_byte = 0; m_hold = 0; m_word = '0; s1 = 0; s2 = 0;
    end else begin
      automatic logic old_s2 = s2;
      s2 = s1; s1 = host_ack;
      if (m_phase == 0) begin
        if (in_valid) begin m_word = 32'(in_data); m_byte = 0; m_phase = 1; end
      end else if (m_phase == 1) begin
        if (old_s2) begin m_phase = 2; m_hold = 0; end
      end else begin
        m_hold++;
        if (!old_s2 && m_hold >= GAP) begin
          if (m_byte == 3) m_phase = 0;
          else begin m_byte++; m_phase = 1; end
        end
      end
    end
  end

  // per-cycle comparison against the reference (R1,R2,R3,R4,R7,R8,R10)
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic exp_f = (m_phase != 1);
      automatic logic [7:0] exp_d = (m_phase == 1) ? m_word[8*m_byte +: 8] : 8'h00;
      automatic logic exp_r = (m_phase == 0);
      chk(frame_n == exp_f, "R4 frame_n timing", frame_n, exp_f);
      chk(bus_data == exp_d, "R3 bus_data content", bus_data, exp_d);
      chk(in_ready == exp_r, "R8 in_ready", in_ready, exp_r);
      if (frame_n) chk(bus_data == 8'h00, "R2 quiet bus", bus_data, 0);
    end
  end

  // gap length between chunks of one word (R5)
  int run = 0;
  logic prev_f = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready) run = 0;
      else if (frame_n) run++;
      else begin
        if (prev_f && run > 0) chk(run >= GAP, "R5 min gap", run, GAP);
        run = 0;
      end
      prev_f = frame_n;
    end
  end

  // host responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!frame_n && !host_ack) begin
        if (cnt >= ack_delay) begin rx_q.push_back(bus_data); host_ack = 1'b1; cnt = 0; end
        else cnt++;
      end else if (frame_n && host_ack) begin
        if (cnt >= drop_delay) begin host_ack = 1'b0; cnt = 0; end
        else cnt++;
      end else cnt = 0;
    end
  end

  task automatic send_word(input logic [SW-1:0] w, input int ad, input int dd, input bit busy_offer);
    logic [31:0] got;
    ack_delay = ad; drop_delay = dd;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    chk(!frame_n, "R10 first chunk after accept", frame_n, 0);
    if (busy_offer) begin
      in_data = ~w;
      for (int i = 0; i < 8; i++) begin
        chk(!in_ready, "R8 busy not ready", in_ready, 0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    while (rx_q.size() < 4) @(negedge clk);
    got = {rx_q[3], rx_q[2], rx_q[1], rx_q[0]};
    rx_q.delete();
    chk(got == 32'(w), "R6 chunk order", got, 32'(w));
    chk(got[31:24] == 8'h00, "R9 zero-extended top chunk", got[31:24], 0);
    while (!in_ready) @(negedge clk);
    chk(frame_n && in_ready, "R7 back to idle", {frame_n, in_ready}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(frame_n == 1'b1, "R1 reset frame_n", frame_n, 1);
    chk(bus_data == 8'h00, "R1 reset bus_data", bus_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && frame_n && bus_data == 0, "R1 idle outputs", {in_ready, frame_n, bus_data}, 10'h300);
    send_word(24'hA5C3E1, 1, 0, 1'b0);
    send_word(24'h123456, 3, 5, 1'b1);
    send_word(24'hFFFFFF, 0, 0, 1'b0);
    send_word(24'h000001, 2, 1, 1'b1);
    send_word(24'h80FF7E, 0, 4, 1'b0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule